// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time-of-Day Counter

This block keeps a 64-bit time of day in nanoseconds for a precision time protocol clock. A 32-bit phase accumulator adds a programmable addend on every reference clock edge. Each time that addition carries out of bit 31, the time counter moves forward by a programmed nominal period of up to 1023 ns. The average tick rate is therefore addend / 2^32 of the reference rate. Software trims the frequency in parts per billion by rewriting the addend. The nominal addend is ceil(2^32 / R), where R is the reference-to-nominal frequency ratio and R is above 1.

Software drives a simple register port with single-cycle write and read strobes. The port lets software set the time, read the time coherently as two 32-bit words, step the time by a signed 64-bit offset in one atomic cycle, and start, stop or clear the counting. The current time is also presented in parallel on `time_ns` for local timestamping logic.

Register addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | control |
| 1 | addend |
| 2 | time low |
| 3 | time high |
| 4 | offset low |
| 5 | offset high |

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, every register (addresses 0 to 5) reads zero and `time_ns` is zero.
- R2: On each clock edge while enabled, the accumulator becomes accumulator + addend modulo 2^32. When that sum carries out, `time_ns` advances by the period field of the control register.
- R3: While the enable bit (control bit 2) is 0, neither the accumulator nor the time changes unless software writes it.
- R4: A control write with bit 5 set clears the accumulator and the time at that edge. Bit 5 always reads back 0. The other control fields take the value written in the same write.
- R5: A read of address 2 returns the live low 32 bits of the time. The same read copies the high 32 bits into a shadow register. A read of address 3 returns that shadow, so the two words of a 64-bit read are coherent.
- R6: A write to address 2 only stages the low word; it does not change the time. A write to address 3 loads {written value, staged low word} into the time at that edge. Any carry in that cycle is dropped. The accumulator keeps running.
- R7: A write to address 4 stages the low half of a signed offset. A write to address 5 adds the 64-bit offset {written value, staged low} to the time at that edge. If a carry falls in the same cycle, the period is added as well, so no tick is lost.
- R8: A write to address 1 changes the addend. The new value is first used in the accumulation at the edge after the write.
- R9: Control reads back the period in bits 25:16, enable in bit 2 and a 2-bit clock select in bits 1:0. All other bits read 0. Addresses 1, 4 and 5 read back the last value written.
- R10: The time wraps modulo 2^64 and the accumulator wraps modulo 2^32, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the cycle of the read strobe |
| time_ns | output | 64 | Current time of day in nanoseconds |

## Verification
The collision that matters is an accumulator carry landing in the same edge as a software time write, an offset step, or a soft reset. Each of these must combine with the carry in its own defined way:
- a time load drops the carry;
- a step adds both the offset and the period;
- a soft reset wins over everything.

The collision is provoked with an addend of 0x80000000, which carries on every second edge. Steps and loads are issued on both parities of that pattern. Random mixes with addends near 2^32 also make carries frequent. The outcome is judged by comparing `time_ns` after every edge against a cycle-level model built from the requirements.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int PER_W  = 10;
  localparam int SEL_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 3'd0,
    RA_ADDEND  = 3'd1,
    RA_TIME_LO = 3'd2,
    RA_TIME_HI = 3'd3,
    RA_OFFS_LO = 3'd4,
    RA_OFFS_HI = 3'd5
  } reg_addr_e;

  localparam int CB_SEL_LSB = 0;
  localparam int CB_ENABLE  = 2;
  localparam int CB_SRST    = 5;
  localparam int CB_PER_LSB = 16;
endpackage

// File: rtl/ptpc_phase_acc.sv
module ptpc_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [ACC_W-1:0] addend,
  output logic             carry
);
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, addend};
    carry = en & ~clr & sum[ACC_W];
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc_q)); // R3
  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0)); // R4
endmodule

// File: rtl/ptpc_tod_counter.sv
module ptpc_tod_counter #(
  parameter int CNT_W = 64,
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [CNT_W-1:0] step_val,
  output logic [CNT_W-1:0] cnt
);
  localparam int PAD_W = CNT_W - PER_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, inc;

  always_comb begin
    inc   = tick ? {{PAD_W{1'b0}}, period} : '0;
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (step) cnt_d = cnt_q + step_val + inc;
    else           cnt_d = cnt_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick && !load && !step) |=> $stable(cnt_q)); // R3
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R4
  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (cnt_q == $past(load_val))); // R6
endmodule

// File: rtl/ptpc_regif.sv
module ptpc_regif
  import ptpc_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int ACC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic              enable,
  output logic [PER_W-1:0]  period,
  output logic [ACC_W-1:0]  addend,
  output logic              srst,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              step,
  output logic [CNT_W-1:0]  step_val
);
  logic              en_q, en_d;
  logic [PER_W-1:0]  per_q, per_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [ACC_W-1:0]  add_q, add_d;
  logic [DATA_W-1:0] stlo_q, stlo_d;
  logic [DATA_W-1:0] shad_q, shad_d;
  logic [DATA_W-1:0] offlo_q, offlo_d;
  logic [DATA_W-1:0] offhi_q, offhi_d;

  logic wr_ctrl, wr_add, wr_tlo, wr_thi, wr_olo, wr_ohi, rd_tlo;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    wr_add  = reg_wr && (reg_addr == RA_ADDEND);
    wr_tlo  = reg_wr && (reg_addr == RA_TIME_LO);
    wr_thi  = reg_wr && (reg_addr == RA_TIME_HI);
    wr_olo  = reg_wr && (reg_addr == RA_OFFS_LO);
    wr_ohi  = reg_wr && (reg_addr == RA_OFFS_HI);
    rd_tlo  = reg_rd && (reg_addr == RA_TIME_LO);
  end

  always_comb begin
    en_d    = wr_ctrl ? reg_wdata[CB_ENABLE] : en_q;
    per_d   = wr_ctrl ? reg_wdata[CB_PER_LSB +: PER_W] : per_q;
    sel_d   = wr_ctrl ? reg_wdata[CB_SEL_LSB +: SEL_W] : sel_q;
    add_d   = wr_add  ? reg_wdata[ACC_W-1:0] : add_q;
    stlo_d  = wr_tlo  ? reg_wdata : stlo_q;
    shad_d  = rd_tlo  ? cnt[CNT_W-1:DATA_W] : shad_q;
    offlo_d = wr_olo  ? reg_wdata : offlo_q;
    offhi_d = wr_ohi  ? reg_wdata : offhi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      per_q   <= '0;
      sel_q   <= '0;
      add_q   <= '0;
      stlo_q  <= '0;
      shad_q  <= '0;
      offlo_q <= '0;
      offhi_q <= '0;
    end else begin
      en_q    <= en_d;
      per_q   <= per_d;
      sel_q   <= sel_d;
      add_q   <= add_d;
      stlo_q  <= stlo_d;
      shad_q  <= shad_d;
      offlo_q <= offlo_d;
      offhi_q <= offhi_d;
    end
  end

  always_comb begin
    enable   = en_q;
    period   = per_q;
    addend   = add_q;
    srst     = wr_ctrl && reg_wdata[CB_SRST];
    load     = wr_thi;
    load_val = {reg_wdata, stlo_q};
    step     = wr_ohi;
    step_val = {reg_wdata, offlo_q};
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_PER_LSB +: PER_W] = per_q;
        reg_rdata[CB_ENABLE]           = en_q;
        reg_rdata[CB_SEL_LSB +: SEL_W] = sel_q;
      end
      RA_ADDEND:  reg_rdata = add_q;
      RA_TIME_LO: reg_rdata = cnt[DATA_W-1:0];
      RA_TIME_HI: reg_rdata = shad_q;
      RA_OFFS_LO: reg_rdata = offlo_q;
      RA_OFFS_HI: reg_rdata = offhi_q;
      default:    reg_rdata = '0;
    endcase
  end

  AST_SHADOW_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tlo |=> (shad_q == $past(cnt[CNT_W-1:DATA_W]))); // R5
  AST_ADDEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_add |=> $stable(add_q)); // R8
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptpc_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CNT_W-1:0]  time_ns
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             enable, srst, load, step, carry;
  logic [PER_W-1:0] period;
  logic [ACC_W-1:0] addend;
  logic [CNT_W-1:0] load_val, step_val, cnt;

  ptpc_regif #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_regif (
    .clk(clk), .rst_n(rst_sync_q),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt(cnt),
    .enable(enable), .period(period), .addend(addend), .srst(srst),
    .load(load), .load_val(load_val), .step(step), .step_val(step_val)
  );

  ptpc_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_q), .en(enable), .clr(srst),
    .addend(addend), .carry(carry)
  );

  ptpc_tod_counter #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_q), .clr(srst), .tick(carry),
    .period(period), .load(load), .load_val(load_val),
    .step(step), .step_val(step_val), .cnt(cnt)
  );

  assign time_ns = cnt;

  AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    carry |-> enable); // R3
endmodule

// File: tb/tb_ptp_tod_clock.sv
`timescale 1ns/1ps
module tb_ptp_tod_clock;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] time_ns;

  always #2.5 clk = ~clk;

  ptp_tod_clock dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_ns(time_ns)
  );

  int nchk = 0;
  int nerr = 0;

  // model state, built from the requirements
  logic [31:0] m_acc, m_add, m_stlo, m_shad, m_offlo, m_offhi;
  logic [63:0] m_cnt;
  logic        m_en;
  logic [9:0]  m_per;
  logic [1:0]  m_sel;
  logic [31:0] rdat;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(logic [9:0] per, logic en, logic sr, logic [1:0] sel);
    return (32'(per) << 16) | (32'(sr) << 5) | (32'(en) << 2) | 32'(sel);
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return ctrl_word(m_per, m_en, 1'b0, m_sel);
      3'd1: return m_add;
      3'd2: return m_cnt[31:0];
      3'd3: return m_shad;
      3'd4: return m_offlo;
      3'd5: return m_offhi;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_edge(logic wr, logic rd, logic [2:0] a, logic [31:0] d);
    logic [32:0] sum;
    logic        cy, sr;
    logic [63:0] inc;
    sr  = wr && a == 3'd0 && d[5];
    sum = {1'b0, m_acc} + {1'b0, m_add};
    cy  = m_en && !sr && sum[32];
    inc = cy ? 64'(m_per) : 64'd0;
    if (rd && a == 3'd2) m_shad = m_cnt[63:32];
    if (sr)                     m_cnt = 64'd0;
    else if (wr && a == 3'd3)   m_cnt = {d, m_stlo};
    else if (wr && a == 3'd5)   m_cnt = m_cnt + {d, m_offlo} + inc;
    else                        m_cnt = m_cnt + inc;
    if (sr) m_acc = 32'd0;
    else if (m_en) m_acc = sum[31:0];
    if (wr) begin
      case (a)
        3'd0: begin m_per = d[25:16]; m_en = d[2]; m_sel = d[1:0]; end
        3'd1: m_add = d;
        3'd2: m_stlo = d;
        3'd4: m_offlo = d;
        3'd5: m_offhi = d;
        default: ;
      endcase
    end
  endtask

  task automatic bus(logic wr, logic rd, logic [2:0] a, logic [31:0] d, string tag);
    logic [31:0] e;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    #1;
    rdat = reg_rdata;
    if (rd) begin
      e = exp_rd(a);
      check(tag, {32'd0, rdat}, {32'd0, e});
    end
    @(posedge clk);
    model_edge(wr, rd, a, d);
    #1;
    reg_wr = 1'b0; reg_rd = 1'b0;
    check("R2 time_ns per edge", time_ns, m_cnt);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) bus(1'b0, 1'b0, 3'd0, 32'd0, "idle");
  endtask

  task automatic read64(string tag);
    logic [63:0] e;
    logic [31:0] lo;
    e = m_cnt;
    bus(1'b0, 1'b1, 3'd2, 32'd0, tag);
    lo = rdat;
    bus(1'b0, 1'b1, 3'd3, 32'd0, tag);
    check(tag, {rdat, lo}, e);
  endtask

  task automatic set_time(logic [63:0] t);
    bus(1'b1, 1'b0, 3'd2, t[31:0], "R6 stage");
    bus(1'b1, 1'b0, 3'd3, t[63:32], "R6 load");
  endtask

  task automatic step_by(logic [63:0] o);
    bus(1'b1, 1'b0, 3'd4, o[31:0], "R7 stage");
    bus(1'b1, 1'b0, 3'd5, o[63:32], "R7 step");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] t0, off;
    logic [31:0] adds [6];
    void'($urandom(32'd1588));
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    m_acc = 0; m_add = 0; m_stlo = 0; m_shad = 0; m_offlo = 0; m_offhi = 0;
    m_cnt = 0; m_en = 0; m_per = 0; m_sel = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check("R1 time_ns", time_ns, 64'd0);
    for (int a = 0; a < 6; a++) begin
      bus(1'b0, 1'b1, 3'(a), 32'd0, "R1 reset readback");
      check("R1 reg zero", {32'd0, rdat}, 64'd0);
    end

    // R9 control fields, R6 staging does not touch time
    bus(1'b1, 1'b0, 3'd0, 32'hFFFF_FFDB, "R9 ctrl wr");
    bus(1'b0, 1'b1, 3'd0, 32'd0, "R9 ctrl rd");
    check("R9 ctrl mask", {32'd0, rdat}, {32'd0, ctrl_word(10'h3FF, 1'b0, 1'b0, 2'b11)});
    bus(1'b1, 1'b0, 3'd2, 32'h1234_5678, "R6 stage only");
    check("R6 stage leaves time", time_ns, 64'd0);

    // R8 addend timing, R2 carry every other edge
    bus(1'b1, 1'b0, 3'd0, ctrl_word(10'd10, 1'b0, 1'b1, 2'd1), "R4 clr");
    bus(1'b1, 1'b0, 3'd1, 32'h8000_0000, "R8 addend");
    bus(1'b1, 1'b0, 3'd0, ctrl_word(10'd10, 1'b1, 1'b0, 2'd1), "R2 enable");
    t0 = time_ns;
    idle(10);
    check("R2 five carries in ten edges", time_ns - t0, 64'd50);

    // R7 step colliding with carry on both parities
    step_by(64'd1000);
    step_by(-64'd7);
    bus(1'b1, 1'b0, 3'd5, 32'd0, "R7 repeat step");
    idle(1);
    step_by(64'd3);
    read64("R5 coherent read");
    set_time(64'h0000_0001_FFFF_FFFF);
    read64("R5 across word carry");
    idle(1);
    set_time(64'd500);
    check("R6 loaded", time_ns, 64'd500);

    // R3 disable freezes
    bus(1'b1, 1'b0, 3'd0, ctrl_word(10'd10, 1'b0, 1'b0, 2'd1), "R3 disable");
    t0 = time_ns;
    idle(20);
    check("R3 frozen", time_ns, t0);
    step_by(64'd100);
    check("R3 step while off", time_ns, t0 + 64'd100);

    // R4 soft reset while running
    bus(1'b1, 1'b0, 3'd0, ctrl_word(10'd8, 1'b1, 1'b0, 2'd2), "R4 run");
    idle(5);
    bus(1'b1, 1'b0, 3'd0, ctrl_word(10'd8, 1'b1, 1'b1, 2'd2), "R4 srst");
    check("R4 cleared", time_ns, 64'd0);
    bus(1'b0, 1'b1, 3'd0, 32'd0, "R4 bit5 reads zero");

    // R10 wrap of time
    bus(1'b1, 1'b0, 3'd1, 32'hFFFF_FFFF, "R10 addend");
    bus(1'b1, 1'b0, 3'd0, ctrl_word(10'd16, 1'b1, 1'b0, 2'd0), "R10 per");
    set_time(64'hFFFF_FFFF_FFFF_FFF8);
    idle(4);
    read64("R10 wrapped read");
    check("R10 wrapped low", {63'd0, time_ns < 64'h100}, 64'd1);

    // random mixes for several addends
    adds[0] = 32'h9999_99A4; adds[1] = 32'hFFFF_FFFF; adds[2] = 32'd1;
    adds[3] = 32'hCCCC_CCCD; adds[4] = $urandom; adds[5] = $urandom;
    for (int k = 0; k < 6; k++) begin
      bus(1'b1, 1'b0, 3'd1, adds[k], "R8 addend set");
      bus(1'b1, 1'b0, 3'd0, ctrl_word(10'($urandom_range(1, 1023)), 1'b1, 1'b0,
          2'($urandom)), "R2 run");
      for (int i = 0; i < 300; i++) begin
        int r;
        r = $urandom_range(0, 99);
        if (r < 70) idle(1);
        else if (r < 80) read64("R5 random read");
        else if (r < 85) begin
          off = {{32{1'b0}}, 32'($urandom)};
          if ($urandom_range(0, 1) == 1) off = -off;
          step_by(off);
        end else if (r < 90) begin
          m_add = m_add;
          bus(1'b1, 1'b0, 3'd1, adds[k] + 32'($urandom_range(0, 4000)) - 32'd2000,
              "R8 trim");
        end else if (r < 95) set_time({32'($urandom), 32'($urandom)});
        else if (r < 97) bus(1'b1, 1'b0, 3'd0, ctrl_word(m_per, ~m_en, 1'b0, m_sel), "R3 toggle");
        else bus(1'b0, 1'b1, 3'($urandom_range(0, 5)), 32'd0, "R9 random readback");
      end
      read64("R2 random end");
    end

    summary();
    $finish;
  end
endmodule